// File: doc/BRIEF.md
# Fractional Timebase Prescaler

This block produces the advance of a free-running 64-bit system timer counter. Each cycle in which the chosen source enable is high, a 31-bit fractional accumulator is increased by a programmable 32-bit prescaler value. Whenever the sum reaches 2^31 the block emits a tick and keeps only the remainder. The average tick rate is therefore the source rate times the prescaler divided by 2^31. A prescaler of 0x80000000 gives exactly one tick per enabled source cycle.

Two clock-enable inputs stand in for two candidate timer sources, the crystal oscillator and an alternate clock. Both live in the one clock domain of the block. A control register picks the source and sets whether each tick adds one or two to the counter. Software programs the block through a small single-cycle register port.

Top module: `frac_timebase`

## Requirements
- R1: While reset is asserted, and until it has been released synchronously, `count_o` is 0, `tick_o` is 0, and both registers read 0. No ticks occur after reset until a non-zero prescaler is written.
- R2: The register at offset 0x000 is the control register. Only bit 8 (source select) and bit 9 (step select) are stored, and all other bits read as 0. The register at offset 0x008 is the prescaler, with all 32 bits stored. Any other offset reads 0, and writes to it change no register.
- R3: In each cycle where the selected enable is high, the prescaler is added to the accumulator. A tick is produced when the sum is at least 2^31, and the accumulator keeps the sum modulo 2^31. In cycles where the enable is low, the accumulator holds its value.
- R4: With a prescaler of 0x80000000, every enabled source cycle produces exactly one tick.
- R5: A prescaler above 0x80000000 acts as 0x80000000: at most one tick per enabled source cycle, and a tick on every enabled cycle.
- R6: Control bit 8 = 0 selects `osc_en`; bit 8 = 1 selects `alt_en`. The enable that is not selected has no effect on ticks or on the counter.
- R7: Control bit 9 = 0 makes each tick add 1 to `count_o`; bit 9 = 1 makes each tick add 2. The counter changes only in a tick cycle, and it wraps modulo 2^64.
- R8: With a prescaler of 0, no tick is produced, whatever the enables do.
- R9: `tick_o` and the matching counter update both appear one clock after the enable cycle that caused them. A register write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| osc_en | input | 1 | Crystal oscillator source enable |
| alt_en | input | 1 | Alternate source enable |
| tick_o | output | 1 | One-cycle tick strobe |
| count_o | output | 64 | Timer counter value |

## Verification
Four properties are checked on every cycle:
- a tick is always caused by the selected enable;
- the counter moves only on a tick, and by the programmed step;
- a zero prescaler stays silent;
- a prescaler at or above unity ticks on every enabled cycle.

The bench scenarios cover what a cycle-local property cannot show. These are the exact tick pattern of fractional ratios such as one third or one half, the register masking and the ignoring of unmapped offsets, and the source-switch behaviour with the accumulator remainder carried across settings.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
  localparam int PRE_W   = 32;
  localparam int CNT_W   = 64;
  localparam int ADDR_W  = 8;
  localparam int SRC_BIT  = 8;
  localparam int STEP_BIT = 9;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PRESC = 8'h08;
endpackage

// File: rtl/ftb_regs.sv
module ftb_regs
  import ftb_pkg::*;
#(
  parameter int DW = PRE_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sel_alt,
  output logic          step2,
  output logic [DW-1:0] presc
);
  logic          src_q, src_d;
  logic          stp_q, stp_d;
  logic [DW-1:0] pre_q, pre_d;
  logic          ctrl_hit, pre_hit;

  assign ctrl_hit = (addr == AW'(OFF_CTRL));
  assign pre_hit  = (addr == AW'(OFF_PRESC));

  always_comb begin
    src_d = src_q;
    stp_d = stp_q;
    pre_d = pre_q;
    if (wr && ctrl_hit) begin
      src_d = wdata[SRC_BIT];
      stp_d = wdata[STEP_BIT];
    end
    if (wr && pre_hit) pre_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      stp_q <= 1'b0;
      pre_q <= '0;
    end else begin
      src_q <= src_d;
      stp_q <= stp_d;
      pre_q <= pre_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[SRC_BIT]  = src_q;
      rdata[STEP_BIT] = stp_q;
    end else if (pre_hit) begin
      rdata = pre_q;
    end
  end

  assign sel_alt = src_q;
  assign step2   = stp_q;
  assign presc   = pre_q;
endmodule

// File: rtl/ftb_accum.sv
module ftb_accum
  import ftb_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] presc,
  output logic          tick_next,
  output logic          tick_q
);
  localparam int FW = PW - 1;
  localparam logic [PW-1:0] UNITY = PW'(1) << FW;

  logic [FW-1:0] acc_q, acc_d;
  logic [PW-1:0] add_val;
  logic [PW-1:0] sum;

  always_comb begin
    add_val   = (presc > UNITY) ? UNITY : presc;
    sum       = {1'b0, acc_q} + add_val;
    tick_next = en & sum[PW-1];
    acc_d     = en ? sum[FW-1:0] : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_next;
    end
  end
endmodule

// File: rtl/ftb_counter.sv
module ftb_counter
  import ftb_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          step2,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] inc;

  always_comb begin
    inc   = step2 ? CW'(2) : CW'(1);
    cnt_d = adv ? cnt_q + inc : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/frac_timebase.sv
module frac_timebase
  import ftb_pkg::*;
#(
  parameter int DW     = PRE_W,
  parameter int CW     = CNT_W,
  parameter int AW     = ADDR_W,
  parameter int SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          osc_en,
  input  logic          alt_en,
  output logic          tick_o,
  output logic [CW-1:0] count_o
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  logic              ctrl_alt, ctrl_step2;
  logic [DW-1:0]     presc_val;
  logic              src_en;
  logic              tick_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  ftb_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .sel_alt (ctrl_alt),
    .step2   (ctrl_step2),
    .presc   (presc_val)
  );

  assign src_en = ctrl_alt ? alt_en : osc_en;

  ftb_accum #(.PW(DW)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (src_en),
    .presc     (presc_val),
    .tick_next (tick_next),
    .tick_q    (tick_o)
  );

  ftb_counter #(.CW(CW)) u_count (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (tick_next),
    .step2 (ctrl_step2),
    .count (count_o)
  );
endmodule

// File: rtl/frac_timebase_chk.sv
module frac_timebase_chk #(
  parameter int DW = 32,
  parameter int CW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_en,
  input logic          alt_en,
  input logic          sel_alt,
  input logic          step2,
  input logic [DW-1:0] presc,
  input logic          tick_o,
  input logic [CW-1:0] count_o
);
  localparam logic [DW-1:0] UNITY = DW'(1) << (DW - 1);

  logic chosen;
  assign chosen = sel_alt ? alt_en : osc_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (count_o == '0 && !tick_o);
    end
  end

  a_r6_tick_from_selected: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(chosen));

  a_r7_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> count_o == $past(count_o) + ($past(step2) ? CW'(2) : CW'(1)));

  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |-> $stable(count_o));

  a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(presc == '0) |-> !tick_o);

  a_r5_unity_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chosen && presc >= UNITY) |-> tick_o);
endmodule

bind frac_timebase frac_timebase_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .osc_en  (osc_en),
  .alt_en  (alt_en),
  .sel_alt (ctrl_alt),
  .step2   (ctrl_step2),
  .presc   (presc_val),
  .tick_o  (tick_o),
  .count_o (count_o)
);

// File: tb/frac_timebase_test.sv
`timescale 1ns/1ps
module frac_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        osc_en, alt_en;
  logic        tick_o;
  logic [63:0] count_o;

  always #2 clk = ~clk;

  frac_timebase uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .osc_en(osc_en),
    .alt_en(alt_en), .tick_o(tick_o), .count_o(count_o)
  );

  typedef struct {
    logic        tick;
    logic [63:0] cnt;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // reference state, built from the requirements
  logic        m_alt, m_step2;
  logic [31:0] m_pre;
  logic [32:0] m_acc;
  logic [63:0] m_cnt;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic o, input logic a, input string req);
    exp_t e;
    logic [32:0] s;
    logic [31:0] p;
    @(negedge clk);
    reg_wr = 1'b0; osc_en = o; alt_en = a;
    e.tick = 1'b0;
    if (m_alt ? a : o) begin
      p = (m_pre > 32'h8000_0000) ? 32'h8000_0000 : m_pre;
      s = m_acc + {1'b0, p};
      if (s >= 33'h0_8000_0000) begin
        e.tick = 1'b1;
        s = s - 33'h0_8000_0000;
        m_cnt = m_cnt + (m_step2 ? 64'd2 : 64'd1);
      end
      m_acc = s;
    end
    e.cnt = m_cnt; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic write_reg(input logic [7:0] ad, input logic [31:0] d, input string req);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = ad; reg_wdata = d; osc_en = 1'b0; alt_en = 1'b0;
    e.tick = 1'b0; e.cnt = m_cnt; e.req = req;
    exp_q.push_back(e);
    if (ad == 8'h00) begin m_alt = d[8]; m_step2 = d[9]; end
    if (ad == 8'h08) m_pre = d;
  endtask

  task automatic read_check(input logic [7:0] ad, input logic [31:0] x, input string req);
    exp_t e;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = ad; osc_en = 1'b0; alt_en = 1'b0;
    e.tick = 1'b0; e.cnt = m_cnt; e.req = req;
    exp_q.push_back(e);
    #1;
    check(reg_rdata == x, req, 64'(reg_rdata), 64'(x));
  endtask

  // monitor: compares each expected item one step after its driving edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(tick_o == e.tick, {e.req, " tick"}, 64'(tick_o), 64'(e.tick));
      check(count_o == e.cnt, {e.req, " count"}, count_o, e.cnt);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    m_alt = 0; m_step2 = 0; m_pre = 0; m_acc = 0; m_cnt = 0;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; osc_en = 0; alt_en = 0;
    repeat (3) @(negedge clk);
    // R1: outputs and registers at reset
    check(count_o == 0, "R1 count", count_o, 0);
    check(tick_o == 0, "R1 tick", 64'(tick_o), 0);
    reg_addr = 8'h08; #1;
    check(reg_rdata == 0, "R1 presc", 64'(reg_rdata), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_check(8'h00, 32'h0, "R1");

    // R8: zero prescaler, enables busy
    for (int i = 0; i < 10; i++) cycle(1'b1, 1'b1, "R8");

    // R2: register masking and unmapped offsets
    write_reg(8'h00, 32'hFFFF_FFFF, "R2");
    read_check(8'h00, 32'h0000_0300, "R2");
    write_reg(8'h00, 32'h0, "R2");
    read_check(8'h00, 32'h0, "R2");
    write_reg(8'h08, 32'h1234_5678, "R2");
    read_check(8'h08, 32'h1234_5678, "R2");
    write_reg(8'h04, 32'hFFFF_FFFF, "R2");
    read_check(8'h04, 32'h0, "R2");
    read_check(8'h00, 32'h0, "R2");
    read_check(8'h08, 32'h1234_5678, "R2");
    write_reg(8'h08, 32'h0, "R2");

    // R4: unity ratio
    write_reg(8'h08, 32'h8000_0000, "R4");
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, "R4");

    // R3: half and one-third ratios, gaps in the enable, R9 timing
    write_reg(8'h08, 32'h4000_0000, "R3");
    for (int i = 0; i < 12; i++) cycle(i % 3 != 0, 1'b0, "R3");
    write_reg(8'h08, 32'h2AAA_AAAB, "R9");
    for (int i = 0; i < 24; i++) cycle(1'b1, 1'b0, "R3");

    // R5: over-unity clamp
    write_reg(8'h08, 32'hFFFF_FFFF, "R5");
    for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, "R5");
    write_reg(8'h08, 32'h9000_0001, "R5");
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, "R5");

    // R6: alternate source selected, oscillator ignored
    write_reg(8'h00, 32'h0000_0100, "R6");
    write_reg(8'h08, 32'h8000_0000, "R6");
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0, "R6");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, "R6");

    // R7: step of two
    write_reg(8'h00, 32'h0000_0300, "R7");
    for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, "R7");
    write_reg(8'h08, 32'h6000_0000, "R7");
    for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, "R7");

    cycle(1'b0, 1'b0, "R9");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule